// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit handles the data side of memory accesses for a 32-bit processor with word-wide data memory. For stores, it turns an operation code, the two low bits of the effective address and the register value into memory write data and four byte strobes. For loads, it takes the fetched memory word, picks out the addressed byte or halfword, and extends it to 32 bits. Unsigned loads fill the upper bits with zeros. Signed loads fill them with copies of the value's top bit.

Byte lanes are big-endian: the byte at address offset 0 sits in bits 31:24 of the memory word. A halfword must start on an even address and a word on a multiple of four. An access that breaks this rule raises a misalignment flag and writes nothing. The unit also forms the upper-immediate result, which puts a 16-bit immediate in the top half and clears the bottom half. An OR with a zero-extended lower half then builds any 32-bit constant.

Store outputs and the misalignment flag are combinational. The load result is registered once, so it appears one clock after the operation is presented.

Top module: `ls_align`

## Requirements
- R1: After reset `ld_result` is zero. Any operation that is not a load, is not upper-immediate, or is a misaligned load gives a zero `ld_result` one cycle later.
- R2: Word load (op 1) at offset 0 gives `ld_result` equal to `rd_data` one cycle later.
- R3: Signed halfword load (op 2) takes `rd_data[31:16]` at offset 0 and `rd_data[15:0]` at offset 2. It sign-extends that halfword, and the result appears one cycle later.
- R4: Unsigned halfword load (op 3) takes the same halfword as R3, zero-extended.
- R5: Signed byte load (op 4) at offset k takes `rd_data[31-8k -: 8]` and sign-extends it.
- R6: Unsigned byte load (op 5) takes the same byte as R5, zero-extended.
- R7: Upper-immediate (op 6) gives `{wr_src[15:0], 16'h0}` one cycle later. An OR with any zero-extended lower 16 bits then equals `{wr_src[15:0], lower}`.
- R8: Word store (op 7) at offset 0 drives `mem_wdata = wr_src` and `mem_be = 4'b1111`.
- R9: Halfword store (op 8) drives `{2{wr_src[15:0]}}` on `mem_wdata`. It sets `mem_be = 4'b1100` at offset 0 and `4'b0011` at offset 2.
- R10: Byte store (op 9) drives `{4{wr_src[7:0]}}` on `mem_wdata` and sets only strobe bit `3-k` for offset k.
- R11: `misalign` is 1 for a word access (op 1 or 7) with a nonzero offset and for a halfword access (op 2, 3 or 8) with an odd offset. Otherwise it is 0. While it is 1, `mem_be` is 0.
- R12: Every operation other than 7, 8 and 9 drives `mem_be = 0` and `mem_wdata = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code: 0 none, 1 LW, 2 LH, 3 LHU, 4 LB, 5 LBU, 6 upper-immediate, 7 SW, 8 SH, 9 SB |
| byte_off | input | 2 | Effective address bits 1:0 |
| wr_src | input | 32 | Register data for stores; bits 15:0 hold the upper-immediate value |
| rd_data | input | 32 | Word read from memory |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_be | output | 4 | Byte write strobes, bit 3 = offset 0 |
| ld_result | output | 32 | Registered load or upper-immediate result |
| misalign | output | 1 | Alignment violation |

## Verification
The hardest cases are the sign boundary and lane choice together. A byte or halfword whose top bit differs from the bits next to it in the word must extend correctly, and only the chosen lane may be picked. The stimulus therefore uses memory words whose four bytes alternate between negative and positive values and differ from each other, and it sweeps every offset. The misaligned cases and the upper-immediate followed by an OR are driven directly, and the OR constant is rebuilt in the bench from the registered result.

// File: rtl/ls_align.sv
module ls_align #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [1:0]    byte_off,
  input  logic [DW-1:0] wr_src,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] mem_wdata,
  output logic [3:0]    mem_be,
  output logic [DW-1:0] ld_result,
  output logic          misalign
);
  localparam int unsigned HW = DW / 2;
  localparam logic [3:0] OP_LW = 4'd1, OP_LH = 4'd2, OP_LHU = 4'd3, OP_LB = 4'd4,
                         OP_LBU = 4'd5, OP_LUI = 4'd6, OP_SW = 4'd7, OP_SH = 4'd8,
                         OP_SB = 4'd9;

  logic          is_word, is_half;
  logic [7:0]    sel_byte;
  logic [HW-1:0] sel_half;
  logic [DW-1:0] ld_next;

  assign is_word  = (op == OP_LW) || (op == OP_SW);
  assign is_half  = (op == OP_LH) || (op == OP_LHU) || (op == OP_SH);
  assign misalign = (is_word && byte_off != 2'd0) || (is_half && byte_off[0]);

  assign sel_byte = rd_data[{~byte_off, 3'b000} +: 8];
  assign sel_half = byte_off[1] ? rd_data[HW-1:0] : rd_data[DW-1:HW];

  always_comb begin
    mem_wdata = '0;
    mem_be    = 4'b0000;
    unique case (op)
      OP_SW: begin
        mem_wdata = wr_src;
        mem_be    = misalign ? 4'b0000 : 4'b1111;
      end
      OP_SH: begin
        mem_wdata = {2{wr_src[HW-1:0]}};
        mem_be    = misalign ? 4'b0000 : (byte_off[1] ? 4'b0011 : 4'b1100);
      end
      OP_SB: begin
        mem_wdata = {4{wr_src[7:0]}};
        mem_be    = 4'b1000 >> byte_off;
      end
      default: ;
    endcase
  end

  always_comb begin
    ld_next = '0;
    if (!misalign) begin
      unique case (op)
        OP_LW:  ld_next = rd_data;
        OP_LH:  ld_next = {{HW{sel_half[HW-1]}}, sel_half};
        OP_LHU: ld_next = {{HW{1'b0}}, sel_half};
        OP_LB:  ld_next = {{(DW-8){sel_byte[7]}}, sel_byte};
        OP_LBU: ld_next = {{(DW-8){1'b0}}, sel_byte};
        OP_LUI: ld_next = {wr_src[HW-1:0], {HW{1'b0}}};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ld_result <= '0;
    else        ld_result <= ld_next;
  end

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> mem_be == 4'b0000); // R11
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SB |-> $countones(mem_be) == 1); // R10
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SH && !misalign) |-> $countones(mem_be) == 2); // R9
  AST_NONSTORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_SW && op != OP_SH && op != OP_SB) |-> mem_be == 4'b0000); // R12
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LW && !misalign) |=> ld_result == $past(rd_data)); // R2
  AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LUI |=> ld_result[HW-1:0] == '0); // R7
  AST_LBU_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LBU |=> ld_result[DW-1:8] == '0); // R6
  AST_LB_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LB |=> (ld_result[DW-1:8] == '0 || ld_result[DW-1:8] == '1)); // R5
  AST_LHU_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LHU |=> ld_result[DW-1:HW] == '0); // R4
endmodule

// File: tb/sim_ls_align.sv
module sim_ls_align;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  op = 0;
  logic [1:0]  byte_off = 0;
  logic [31:0] wr_src = 0, rd_data = 0;
  logic [31:0] mem_wdata, ld_result;
  logic [3:0]  mem_be;
  logic        misalign;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  ls_align u0 (.clk(clk), .rst_n(rst_n), .op(op), .byte_off(byte_off), .wr_src(wr_src),
               .rd_data(rd_data), .mem_wdata(mem_wdata), .mem_be(mem_be),
               .ld_result(ld_result), .misalign(misalign));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_ld(logic [3:0] o, logic [1:0] k, logic [31:0] s, logic [31:0] d);
    logic [7:0] b;
    logic [15:0] h;
    b = d >> (8 * (3 - k));
    h = k[1] ? d[15:0] : d[31:16];
    case (o)
      1: return (k == 0) ? d : 32'h0;
      2: return k[0] ? 32'h0 : {{16{h[15]}}, h};
      3: return k[0] ? 32'h0 : {16'h0, h};
      4: return {{24{b[7]}}, b};
      5: return {24'h0, b};
      6: return {s[15:0], 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(logic [3:0] o, logic [1:0] k, logic [31:0] s, logic [31:0] d, string tag);
    logic [31:0] ew;
    logic [3:0]  eb;
    logic        em;
    @(negedge clk);
    op = o; byte_off = k; wr_src = s; rd_data = d;
    em = ((o == 1 || o == 7) && k != 0) || ((o == 2 || o == 3 || o == 8) && k[0]);
    case (o)
      7: begin ew = s; eb = em ? 4'b0 : 4'b1111; end
      8: begin ew = {s[15:0], s[15:0]}; eb = em ? 4'b0 : (k[1] ? 4'b0011 : 4'b1100); end
      9: begin ew = {4{s[7:0]}}; eb = 4'b0001 << (3 - k); end
      default: begin ew = 0; eb = 0; end
    endcase
    #1;
    check({tag, "/R11 misalign"}, {31'h0, misalign}, {31'h0, em});
    check({tag, "/R12 be"}, {28'h0, mem_be}, {28'h0, eb});
    if (o >= 7 && o <= 9) check({tag, " wdata"}, mem_wdata, ew);
    exp_q.push_back(model_ld(o, k, s, d));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check({tag_q.pop_front(), " ld_result"}, ld_result, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w0, w1;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", ld_result, 32'h0);
    @(negedge clk) rst_n = 1;
    w0 = 32'h8A4C_F172;
    w1 = 32'h7F80_01FE;
    drive(4'd1, 2'd0, 0, w0, "R2 lw");
    drive(4'd1, 2'd0, 0, w1, "R2 lw");
    for (int k = 0; k < 4; k++) begin
      drive(4'd2, 2'(k), 0, w0, "R3 lh");
      drive(4'd2, 2'(k), 0, w1, "R3 lh");
      drive(4'd3, 2'(k), 0, w0, "R4 lhu");
      drive(4'd4, 2'(k), 0, w0, "R5 lb");
      drive(4'd4, 2'(k), 0, w1, "R5 lb");
      drive(4'd5, 2'(k), 0, w0, "R6 lbu");
      drive(4'd1, 2'(k), 0, w1, "R11 lw");
      drive(4'd7, 2'(k), 32'h1234_5678, w0, "R8 sw");
      drive(4'd8, 2'(k), 32'hDEAD_BEEF, w0, "R9 sh");
      drive(4'd9, 2'(k), 32'hCAFE_F00D, w0, "R10 sb");
      drive(4'd0, 2'(k), 32'hFFFF_FFFF, w0, "R12 nop");
      drive(4'd15, 2'(k), 32'hFFFF_FFFF, w1, "R1 badop");
    end
    drive(4'd6, 2'd3, 32'h0000_ABCD, w0, "R7 lui");
    @(negedge clk); op = 0;
    check("R7 lui|ori", ld_result | {16'h0, 16'h8001}, 32'hABCD_8001);
    drive(4'd6, 2'd0, 32'hFFFF_0000, w1, "R7 lui zero");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule